// File: doc/BRIEF.md
# Embedded Operation Status Flag Generator

This block produces the status word that a memory bank returns when the host reads it while an internal program or erase operation is running. An operation sequencer tells it when an operation starts, is suspended, resumes or finishes. It also reports when a sector is added to a pending erase and when an operation has run past its time limit. The block keeps the operation kind, the top bit of the word being programmed, the set of sectors chosen for erase, a programmable sector-acceptance window and a sticky time-limit flag.

On every read strobe it registers one output word. When no operation is pending it passes array data through. A polling bit, two toggle bits, a time-limit bit and a window-closed bit let the host tell these cases apart: program in progress, erase in progress, erase suspended, finished, or timed out. A ready output is low while an operation actually runs. The toggle bits change once per read strobe, not once per clock. The second toggle bit moves only for reads inside the erase set, so the host can find the sectors being erased even while the erase is suspended.

Top module: `op_status_gen`

## Requirements
- R1: After reset, `ready` is 1 and `rd_data` is 0. A read strobe with no operation pending registers `array_data` into `rd_data` on that clock edge.
- R2: A status word has the polling bit at bit 7, toggle A at bit 6, time-limit at bit 5, window-closed at bit 3 and toggle B at bit 2; bits 4, 1 and 0 are 0. During a program, bit 7 returns the complement of `prog_msb` latched at start, bits 3 and 2 are 0, and each read strobe registers the status word into `rd_data`.
- R3: Toggle A and toggle B are cleared when an operation starts. During a program or an erase, toggle A inverts on every read strobe, so the first read after a start returns bit 6 = 1.
- R4: After `op_done` ends a program or an erase, `ready` is 1 and reads return `array_data` again.
- R5: During an erase, bit 7 reads 0. Bit 3 reads 0 while the acceptance window is open and 1 once it has closed. The window opens with length `win_len` cycles at the erase start.
- R6: An `sect_add` pulse during an erase with the window open adds `sect_idx` to the erase set and reloads the window to `win_len`. An `sect_add` pulse after the window has closed changes nothing.
- R7: Toggle B inverts on each read strobe whose `rd_sect` is in the erase set, during both erase and erase-suspend. On any other read it holds its value.
- R8: `op_suspend` during an erase enters the suspended state, and `ready` goes to 1. There, reads inside the erase set return bit 7 = 1, toggle A held, bit 5 = 0 and bit 3 = 1. Reads outside the set return `array_data`. `op_resume` returns to the erase.
- R9: A `time_limit` pulse during a program or an erase sets bit 5 of later status words. The bit stays set until `op_done`, and the next operation starts with it clear.
- R10: `ready` is 0 from the clock edge that starts a program or an erase until that operation ends or is suspended.
- R11: Driving `rst_n` low aborts any operation. The block then returns to idle with all flags clear, `ready` = 1 and array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_start | input | 1 | Start pulse from the sequencer, taken only when idle |
| op_kind | input | 1 | Kind of operation started: 1 = program, 0 = erase |
| prog_msb | input | 1 | Bit 7 of the word being programmed, latched at a program start |
| sect_idx | input | SECT_W | Sector named by an erase start or a sector add |
| sect_add | input | 1 | Adds `sect_idx` to the erase set while the window is open |
| win_len | input | WIN_W | Length of the sector-acceptance window in cycles |
| op_suspend | input | 1 | Suspends a running erase |
| op_resume | input | 1 | Resumes a suspended erase |
| op_done | input | 1 | Ends the running program or erase |
| time_limit | input | 1 | Sequencer signal that the operation overran its time limit |
| rd_strobe | input | 1 | Read strobe, one per host read |
| rd_sect | input | SECT_W | Sector of the read address |
| array_data | input | DATA_W | Array contents at the read address |
| rd_data | output | DATA_W | Registered read result, status or array data |
| ready | output | 1 | 1 when idle or suspended, 0 while an operation runs |

## Verification
Several properties are checked on every cycle. `ready` falls after every start and rises after every completion. The polling bit tracks the latched data bit on each program read, and toggle A changes on each running read but stays frozen while suspended. The time-limit flag stays set until completion, a sector add inside the window keeps the window open, and a read after the window has closed shows bit 3 set. The bench's scenarios are needed for the rest. They show the exact toggle sequences across sectors inside and outside the erase set, that a late sector add is ignored, the suspend/resume round trip, and that a mid-operation reset returns the block to array reads.

// File: rtl/opst_pkg.sv
package opst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_ERASE = 2'd2,
    ST_SUSP  = 2'd3
  } opst_state_t;

  localparam int POLL_BIT = 7;
  localparam int TOGA_BIT = 6;
  localparam int TMO_BIT  = 5;
  localparam int WIN_BIT  = 3;
  localparam int TOGB_BIT = 2;

  function automatic logic is_running(input opst_state_t s);
    return (s == ST_PROG) || (s == ST_ERASE);
  endfunction

endpackage

// File: rtl/opst_ctrl.sv
module opst_ctrl
  import opst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_start,
  input  logic        op_kind,
  input  logic        prog_msb,
  input  logic        op_suspend,
  input  logic        op_resume,
  input  logic        op_done,
  input  logic        time_limit,
  output opst_state_t state_q,
  output logic        pmsb_q,
  output logic        tmo_q
);

  opst_state_t state_d;
  logic        pmsb_en;
  logic        tmo_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (op_start) state_d = op_kind ? ST_PROG : ST_ERASE;
      ST_PROG:  if (op_done) state_d = ST_IDLE;
      ST_ERASE: begin
        if (op_done)         state_d = ST_IDLE;
        else if (op_suspend) state_d = ST_SUSP;
      end
      ST_SUSP:  if (op_resume) state_d = ST_ERASE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign pmsb_en = (state_q == ST_IDLE) && op_start && op_kind;

  always_comb begin
    tmo_d = tmo_q;
    if (state_q == ST_IDLE) begin
      tmo_d = 1'b0;
    end else if (is_running(state_q)) begin
      if (op_done)         tmo_d = 1'b0;
      else if (time_limit) tmo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pmsb_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmo_q   <= tmo_d;
      if (pmsb_en) pmsb_q <= prog_msb;
    end
  end

endmodule

// File: rtl/opst_erase_win.sv
module opst_erase_win
  import opst_pkg::*;
#(
  parameter int SECT_W = 2,
  parameter int WIN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  opst_state_t       state_q,
  input  logic              op_start,
  input  logic              op_kind,
  input  logic              sect_add,
  input  logic [SECT_W-1:0] sect_idx,
  input  logic [WIN_W-1:0]  win_len,
  output logic [(1<<SECT_W)-1:0] sect_mask,
  output logic              win_open
);

  localparam int NSECT = 1 << SECT_W;

  logic [WIN_W-1:0] cnt_q, cnt_d;
  logic [NSECT-1:0] mask_d;
  logic [NSECT-1:0] idx_oh;
  logic             start_erase;
  logic             add_ok;

  genvar g;
  generate
    for (g = 0; g < NSECT; g++) begin : g_oh
      assign idx_oh[g] = (sect_idx == SECT_W'(g));
    end
  endgenerate

  assign win_open    = (cnt_q != '0);
  assign start_erase = (state_q == ST_IDLE) && op_start && !op_kind;
  assign add_ok      = (state_q == ST_ERASE) && sect_add && win_open;

  always_comb begin
    cnt_d = cnt_q;
    if (start_erase || add_ok)                 cnt_d = win_len;
    else if (state_q == ST_ERASE && win_open)  cnt_d = cnt_q - 1'b1;
    else if (state_q == ST_IDLE)               cnt_d = '0;
  end

  always_comb begin
    mask_d = sect_mask;
    if (start_erase)               mask_d = idx_oh;
    else if (add_ok)               mask_d = sect_mask | idx_oh;
    else if (state_q == ST_IDLE)   mask_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sect_mask <= '0;
    end else begin
      cnt_q     <= cnt_d;
      sect_mask <= mask_d;
    end
  end

endmodule

// File: rtl/opst_toggle.sv
module opst_toggle
  import opst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  opst_state_t state_q,
  input  logic        op_start,
  input  logic        rd_strobe,
  input  logic        in_set,
  output logic        tog_a_q,
  output logic        tog_b_q,
  output logic        tog_a_d,
  output logic        tog_b_d
);

  logic clr;
  logic flip_a;
  logic flip_b;

  assign clr    = (state_q == ST_IDLE) && op_start;
  assign flip_a = rd_strobe && is_running(state_q);
  assign flip_b = rd_strobe && in_set &&
                  ((state_q == ST_ERASE) || (state_q == ST_SUSP));

  always_comb begin
    tog_a_d = tog_a_q;
    tog_b_d = tog_b_q;
    if (clr) begin
      tog_a_d = 1'b0;
      tog_b_d = 1'b0;
    end else begin
      if (flip_a) tog_a_d = ~tog_a_q;
      if (flip_b) tog_b_d = ~tog_b_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_a_q <= 1'b0;
      tog_b_q <= 1'b0;
    end else begin
      tog_a_q <= tog_a_d;
      tog_b_q <= tog_b_d;
    end
  end

endmodule

// File: rtl/opst_rdout.sv
module opst_rdout
  import opst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  opst_state_t       state_q,
  input  logic              rd_strobe,
  input  logic              in_set,
  input  logic              pmsb_q,
  input  logic              tmo_q,
  input  logic              win_open,
  input  logic              tog_a_d,
  input  logic              tog_b_d,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    word = '0;
    unique case (state_q)
      ST_IDLE: word = array_data;
      ST_PROG: begin
        word[POLL_BIT] = ~pmsb_q;
        word[TOGA_BIT] = tog_a_d;
        word[TMO_BIT]  = tmo_q;
        word[TOGB_BIT] = tog_b_d;
      end
      ST_ERASE: begin
        word[TOGA_BIT] = tog_a_d;
        word[TMO_BIT]  = tmo_q;
        word[WIN_BIT]  = ~win_open;
        word[TOGB_BIT] = tog_b_d;
      end
      ST_SUSP: begin
        if (in_set) begin
          word[POLL_BIT] = 1'b1;
          word[TOGA_BIT] = tog_a_d;
          word[WIN_BIT]  = 1'b1;
          word[TOGB_BIT] = tog_b_d;
        end else begin
          word = array_data;
        end
      end
      default: word = array_data;
    endcase
  end

  assign rd_d = rd_strobe ? word : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end

endmodule

// File: rtl/op_status_gen.sv
module op_status_gen
  import opst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SECT_W = 2,
  parameter int WIN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic              op_kind,
  input  logic              prog_msb,
  input  logic [SECT_W-1:0] sect_idx,
  input  logic              sect_add,
  input  logic [WIN_W-1:0]  win_len,
  input  logic              op_suspend,
  input  logic              op_resume,
  input  logic              op_done,
  input  logic              time_limit,
  input  logic              rd_strobe,
  input  logic [SECT_W-1:0] rd_sect,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready
);

  localparam int NSECT = 1 << SECT_W;

  logic             rst_s0, rst_s1;
  opst_state_t      state_q;
  logic             pmsb_q, tmo_q;
  logic [NSECT-1:0] sect_mask;
  logic             win_open;
  logic             in_set;
  logic             tog_a_q, tog_b_q, tog_a_d, tog_b_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end

  opst_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s1),
    .op_start(op_start), .op_kind(op_kind), .prog_msb(prog_msb),
    .op_suspend(op_suspend), .op_resume(op_resume), .op_done(op_done),
    .time_limit(time_limit),
    .state_q(state_q), .pmsb_q(pmsb_q), .tmo_q(tmo_q)
  );

  opst_erase_win #(.SECT_W(SECT_W), .WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_s1), .state_q(state_q),
    .op_start(op_start), .op_kind(op_kind),
    .sect_add(sect_add), .sect_idx(sect_idx), .win_len(win_len),
    .sect_mask(sect_mask), .win_open(win_open)
  );

  assign in_set = sect_mask[rd_sect];

  opst_toggle u_tog (
    .clk(clk), .rst_n(rst_s1), .state_q(state_q),
    .op_start(op_start), .rd_strobe(rd_strobe), .in_set(in_set),
    .tog_a_q(tog_a_q), .tog_b_q(tog_b_q),
    .tog_a_d(tog_a_d), .tog_b_d(tog_b_d)
  );

  opst_rdout #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_s1), .state_q(state_q),
    .rd_strobe(rd_strobe), .in_set(in_set),
    .pmsb_q(pmsb_q), .tmo_q(tmo_q), .win_open(win_open),
    .tog_a_d(tog_a_d), .tog_b_d(tog_b_d),
    .array_data(array_data), .rd_data(rd_data)
  );

  assign ready = (state_q == ST_IDLE) || (state_q == ST_SUSP);

  logic unused_tog_b;
  assign unused_tog_b = tog_b_q;

endmodule

// File: rtl/opst_checker.sv
module opst_checker
  import opst_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input opst_state_t state_q,
  input logic        ready,
  input logic        op_start,
  input logic        op_done,
  input logic        rd_strobe,
  input logic [7:0]  rd_low,
  input logic        pmsb_q,
  input logic        tmo_q,
  input logic        sect_add,
  input logic        win_open,
  input logic        tog_a_q
);

  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && op_start) |=> !ready);

  a_r4_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (is_running(state_q) && op_done) |=> ready);

  a_r2_poll_complement: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG && rd_strobe) |=> (rd_low[7] == !pmsb_q));

  a_r3_toga_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (is_running(state_q) && rd_strobe) |=> (tog_a_q != $past(tog_a_q)));

  a_r8_susp_toga_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSP) |=> (tog_a_q == $past(tog_a_q)));

  a_r9_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && is_running(state_q) && !op_done) |=> tmo_q);

  a_r6_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERASE && sect_add && win_open) |=> win_open);

  a_r5_closed_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERASE && rd_strobe && !win_open) |=> rd_low[3]);

endmodule

bind op_status_gen opst_checker u_chk (
  .clk(clk), .rst_n(rst_s1), .state_q(state_q), .ready(ready),
  .op_start(op_start), .op_done(op_done), .rd_strobe(rd_strobe),
  .rd_low(rd_data[7:0]), .pmsb_q(pmsb_q), .tmo_q(tmo_q),
  .sect_add(sect_add), .win_open(win_open), .tog_a_q(tog_a_q)
);

// File: tb/op_status_gen_test.sv
module op_status_gen_test;

  logic       clk;
  logic       rst_n;
  logic       op_start, op_kind, prog_msb, sect_add;
  logic [1:0] sect_idx, rd_sect;
  logic [7:0] win_len;
  logic       op_suspend, op_resume, op_done, time_limit, rd_strobe;
  logic [7:0] array_data, rd_data;
  logic       ready;

  int n_cmp;
  int n_bad;
  logic m_a, m_b;
  logic [7:0] v;
  logic [7:0] pat;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign array_data = {rd_sect, 6'h15} ^ pat;

  op_status_gen uut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .prog_msb(prog_msb), .sect_idx(sect_idx), .sect_add(sect_add),
    .win_len(win_len), .op_suspend(op_suspend), .op_resume(op_resume),
    .op_done(op_done), .time_limit(time_limit), .rd_strobe(rd_strobe),
    .rd_sect(rd_sect), .array_data(array_data), .rd_data(rd_data),
    .ready(ready)
  );

  function automatic logic [7:0] stw(input logic p7, input logic a6,
                                     input logic t5, input logic w3,
                                     input logic b2);
    return {p7, a6, t5, 1'b0, w3, b2, 2'b00};
  endfunction

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_op(input logic kind, input logic msb,
                          input logic [1:0] s, input logic [7:0] w);
    @(negedge clk);
    op_start = 1'b1; op_kind = kind; prog_msb = msb; sect_idx = s; win_len = w;
    @(negedge clk);
    op_start = 1'b0;
    m_a = 1'b0; m_b = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: op_done = 1'b1;
      1: op_suspend = 1'b1;
      2: op_resume = 1'b1;
      3: time_limit = 1'b1;
      default: sect_add = 1'b1;
    endcase
    @(negedge clk);
    op_done = 1'b0; op_suspend = 1'b0; op_resume = 1'b0;
    time_limit = 1'b0; sect_add = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] val);
    @(negedge clk);
    rd_strobe = 1'b1; rd_sect = s;
    @(negedge clk);
    rd_strobe = 1'b0;
    val = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; op_start = 0; op_kind = 0; prog_msb = 0; sect_add = 0;
    sect_idx = 0; rd_sect = 0; win_len = 8'd20; op_suspend = 0;
    op_resume = 0; op_done = 0; time_limit = 0; rd_strobe = 0; pat = 8'h00;
    m_a = 0; m_b = 0;
    do_reset();

    // R1: reset state and idle array reads
    check("R1 reset rd_data", rd_data, 8'h00);
    check("R1 reset ready", {7'b0, ready}, 8'h01);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      check("R1 idle array read", v, {2'(s), 6'h15});
    end

    // R2 R3 R4 R10: program sweep over data bit and array patterns
    for (int p = 0; p < 64; p++) begin
      pat = 8'(p * 37);
      start_op(1'b1, p[0], 2'(p), 8'd5);
      check("R10 busy in program", {7'b0, ready}, 8'h00);
      for (int k = 0; k < 3; k++) begin
        rd(2'(p + k), v);
        m_a = ~m_a;
        check("R2 R3 program status", v, stw(~p[0], m_a, 1'b0, 1'b0, 1'b0));
      end
      pulse(0);
      check("R4 ready after done", {7'b0, ready}, 8'h01);
      rd(2'(p), v);
      check("R4 array after done", v, {2'(p), 6'h15} ^ pat);
    end
    pat = 8'h00;

    // R5 R7 R8: erase sector sweep with suspend/resume
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < 4; r++) begin
        start_op(1'b0, 1'b0, 2'(s), 8'd20);
        check("R10 busy in erase", {7'b0, ready}, 8'h00);
        for (int k = 0; k < 2; k++) begin
          rd(2'(r), v);
          m_a = ~m_a;
          if (r == s) m_b = ~m_b;
          check("R5 R7 erase status", v, stw(1'b0, m_a, 1'b0, 1'b0, m_b));
        end
        pulse(1);
        check("R8 ready in suspend", {7'b0, ready}, 8'h01);
        for (int k = 0; k < 2; k++) begin
          rd(2'(r), v);
          if (r == s) begin
            m_b = ~m_b;
            check("R8 R7 suspend in-set", v, stw(1'b1, m_a, 1'b0, 1'b1, m_b));
          end else begin
            check("R8 suspend array read", v, {2'(r), 6'h15});
          end
        end
        pulse(2);
        check("R8 busy after resume", {7'b0, ready}, 8'h00);
        rd(2'(r), v);
        m_a = ~m_a;
        if (r == s) m_b = ~m_b;
        check("R8 resumed status", v, stw(1'b0, m_a, 1'b0, 1'b0, m_b));
        pulse(0);
      end
    end

    // R5 R6: window closing, sector add inside and after the window
    start_op(1'b0, 1'b0, 2'd0, 8'd6);
    rd(2'd0, v); m_a = ~m_a; m_b = ~m_b;
    check("R5 window open", v, stw(1'b0, m_a, 1'b0, 1'b0, m_b));
    pulse(4); // sect_add with sect_idx still 0 is harmless; set index first
    sect_idx = 2'd2;
    pulse(4);
    idle(3);
    rd(2'd2, v); m_a = ~m_a; m_b = ~m_b;
    check("R6 added sector toggles, window open", v,
          stw(1'b0, m_a, 1'b0, 1'b0, m_b));
    idle(10);
    rd(2'd2, v); m_a = ~m_a; m_b = ~m_b;
    check("R5 window closed", v, stw(1'b0, m_a, 1'b0, 1'b1, m_b));
    sect_idx = 2'd3;
    pulse(4);
    rd(2'd3, v); m_a = ~m_a;
    check("R6 late add ignored", v, stw(1'b0, m_a, 1'b0, 1'b1, m_b));
    rd(2'd1, v); m_a = ~m_a;
    check("R7 out-of-set hold", v, stw(1'b0, m_a, 1'b0, 1'b1, m_b));
    pulse(0);

    // R9: time-limit flag
    start_op(1'b1, 1'b1, 2'd0, 8'd5);
    pulse(3);
    rd(2'd0, v); m_a = ~m_a;
    check("R9 timeout set", v, stw(1'b0, m_a, 1'b1, 1'b0, 1'b0));
    rd(2'd1, v); m_a = ~m_a;
    check("R9 timeout sticky", v, stw(1'b0, m_a, 1'b1, 1'b0, 1'b0));
    pulse(0);
    start_op(1'b0, 1'b0, 2'd1, 8'd20);
    rd(2'd1, v); m_a = ~m_a; m_b = ~m_b;
    check("R9 cleared on next op", v, stw(1'b0, m_a, 1'b0, 1'b0, m_b));
    pulse(3);
    rd(2'd0, v); m_a = ~m_a;
    check("R9 erase timeout", v, stw(1'b0, m_a, 1'b1, 1'b0, m_b));

    // R11: reset aborts operation
    do_reset();
    check("R11 ready after abort", {7'b0, ready}, 8'h01);
    check("R11 rd_data cleared", rd_data, 8'h00);
    rd(2'd1, v);
    check("R11 array after abort", v, {2'd1, 6'h15});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule